// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a supervision timer for a small controller. A prescaler and an 8-bit down counter measure time in watchdog clocks. A watchdog clock is either every peripheral clock cycle, or one out of every 32 pulses of `slow_tick`. `slow_tick` is a single-cycle enable that carries the slow oscillator into the peripheral clock domain. Software programs a load value and a control byte over a simple write-only register bus. To restart the count, software performs a keyed two-write sequence. When the count runs out, the block either raises a reset request (guard mode) or sets a timeout flag that also serves as the interrupt (timer mode).

The bus decodes four addresses. Address 0 is control, address 1 is the load value, address 2 is the first key register and address 3 is the second key register. The control byte holds these fields:

- bit 0: run.
- bit 1: timeout flag. A write of 0 clears it; a write of 1 leaves it unchanged.
- bit 2: clock select. 1 selects the slow tick divided by 32.
- bit 3: guard mode.
- bits 6:4: prescaler select P.

Two state machines do the work. The key sequencer has states `SEQ_IDLE` and `SEQ_ARMED`:

- `SEQ_IDLE` goes to `SEQ_ARMED` on a write of A5h to address 2.
- `SEQ_ARMED` goes back to `SEQ_IDLE` on the next write of any kind. That write is either a valid feed (5Ah to address 3) or a sequence break.

The counter machine has states `CNT_RELOAD` and `CNT_RUN`:

- `CNT_RELOAD` goes to `CNT_RUN` on the first running watchdog tick without a feed in the same cycle. That tick loads the shadow value into the counter.
- `CNT_RUN` goes to `CNT_RELOAD` on a feed or on expiry.

Top module: `wdg_guard`

## Requirements
- R1: After reset the counter output reads FFh, the timeout flag and reset request are 0, and the unit is in timer mode, not running, with peripheral clock and P=0; load and shadow values are FFh.
- R2: In timer mode with control bit 0 clear, the counter output holds its value whatever the clock inputs do.
- R3: While counting, the counter output falls by one once every 2^(5+P) watchdog clocks, with P taken from control bits 6:4, and never wraps below 0.
- R4: The counter expires (L+1)·2^(5+P)+1 watchdog clocks after a restart, where L is the shadow value; the first clock after the restart reloads the counter.
- R5: Writing A5h to address 2 and then 5Ah to address 3 copies the load register (address 1) into the shadow and restarts the count from it. Writing the load register without a feed does not change the count in progress.
- R6: Once A5h has been written to address 2, any next write other than 5Ah to address 3 raises the reset request for one cycle after that write's clock edge; that write is discarded and the sequence returns to idle.
- R7: In guard mode (control bit 3 set), expiry raises the reset request for one cycle and the count restarts from the shadow; the run bit is treated as set.
- R8: In timer mode expiry sets the timeout flag (output `tmo_irq`) without a reset request. A control write with bit 1 at 0 clears it; a write with bit 1 at 1 does not set it; expiry wins over a clear in the same cycle.
- R9: With control bit 2 set, one watchdog clock occurs on every 32nd `slow_tick` pulse. With bit 2 clear, `slow_tick` has no effect on the count.
- R10: While no sequence is armed, a write to address 3, or a write of any value other than A5h to address 2, has no effect and raises no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 load, 2 key one, 3 key two) |
| bus_wdata | input | 8 | Register write data |
| cnt_o | output | 8 | Current down-counter value |
| tmo_irq | output | 1 | Timeout flag / interrupt (timer mode) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench goes after these corner cases:

- **Off-by-one in the timeout.** The spacing between guard-mode reset pulses is measured against (L+1)·2^(5+P)+1. A design that reloads on the feed cycle itself would come up one cycle short. One that reloads at zero rather than on underflow would come up one prescale period short.
- **Sequence breaks.** A write to the load register, a wrong second key, and a repeated first key are each placed between the keys. A sequencer that only watches the key addresses would miss these breaks, or would let the intruding write through.
- **Flag and halt.** A design that counts while halted fails the halted checks. So does one that lets a write of 1 set the flag, or one that clocks from `slow_tick` in peripheral-clock mode.
- **Slow-clock divider.** A divider of the wrong ratio shifts every expiry and is caught by the cycle-by-cycle comparison.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOAD  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_KEY1  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_KEY2  = 2'd3;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic { SEQ_IDLE, SEQ_ARMED } seq_state_e;
    typedef enum logic { CNT_RELOAD, CNT_RUN } cnt_state_e;

    typedef struct packed {
        logic [2:0] presel;
        logic       guard;
        logic       clksel;
        logic       tof;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              feed_ok,
    output logic              seq_err,
    output logic              pass_we,
    output logic              armed
);
    seq_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        feed_ok = 1'b0;
        seq_err = 1'b0;
        pass_we = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                if (we) begin
                    if (addr == ADDR_KEY1 && wdata == KEY_FIRST) st_d = SEQ_ARMED;
                    else if (addr == ADDR_CTRL || addr == ADDR_LOAD) pass_we = 1'b1;
                end
            end
            SEQ_ARMED: begin
                if (we) begin
                    st_d = SEQ_IDLE;
                    if (addr == ADDR_KEY2 && wdata == KEY_SECOND) feed_ok = 1'b1;
                    else seq_err = 1'b1;
                end
            end
        endcase
    end

    assign armed = (st_q == SEQ_ARMED);
endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int DIV_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic clksel,
    output logic wtick
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         div_q <= '0;
        else if (slow_tick) div_q <= div_q + 1'b1;
    end

    assign wtick = clksel ? (slow_tick && (&div_q)) : 1'b1;
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt
    import wdg_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRE_W   = 13,
    parameter int SEL_W   = 3,
    parameter int BASE_SH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wtick,
    input  logic             run_en,
    input  logic [SEL_W-1:0] presel,
    input  logic             feed,
    input  logic [CNT_W-1:0] shadow,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             loading,
    output logic             counting
);
    localparam int MAX_SH = BASE_SH + (1 << SEL_W) - 1;
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    cnt_state_e st_q, st_d;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] tap_mask;
    logic             pre_end;
    logic             adv;

    initial begin
        if (MAX_SH > PRE_W) $error("prescaler too narrow for selected taps");
    end

    assign tap_mask = (ONE << (BASE_SH + int'(presel))) - ONE;
    assign pre_end  = &(pre_q | ~tap_mask);
    assign adv      = wtick && run_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_RELOAD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        unique case (st_q)
            CNT_RELOAD: if (adv && !feed) st_d = CNT_RUN;
            CNT_RUN: begin
                if (feed) st_d = CNT_RELOAD;
                else if (adv && pre_end && cnt == '0) begin
                    expire = 1'b1;
                    st_d   = CNT_RELOAD;
                end
            end
        endcase
    end

    assign loading  = (st_q == CNT_RELOAD) && (st_d == CNT_RUN);
    assign counting = (st_q == CNT_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '1;
            pre_q <= '0;
        end else if (loading) begin
            cnt   <= shadow;
            pre_q <= '0;
        end else if (counting && adv && !feed) begin
            if (pre_end) begin
                pre_q <= '0;
                if (cnt != '0) cnt <= cnt - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRE_W   = 13,
    parameter int SEL_W   = 3,
    parameter int BASE_SH = 5,
    parameter int DIV_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              tmo_irq,
    output logic              rst_req
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] shadow_q;
    logic             feed_ok, seq_err, pass_we, armed_w;
    logic             wtick, expire_w, loading_w, counting_w, run_en;
    logic             ctrl_wr;

    wdg_key_seq u_seq (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .feed_ok(feed_ok), .seq_err(seq_err), .pass_we(pass_we), .armed(armed_w)
    );

    wdg_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .clksel(ctrl_q.clksel), .wtick(wtick)
    );

    assign run_en = ctrl_q.run || ctrl_q.guard;

    wdg_down_cnt #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_SH(BASE_SH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wtick(wtick), .run_en(run_en), .presel(ctrl_q.presel),
        .feed(feed_ok), .shadow(shadow_q), .cnt(cnt_o), .expire(expire_w),
        .loading(loading_w), .counting(counting_w)
    );

    assign ctrl_wr = pass_we && (bus_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            load_q   <= '1;
            shadow_q <= '1;
            rst_req  <= 1'b0;
        end else begin
            rst_req <= seq_err || (expire_w && ctrl_q.guard);
            if (ctrl_wr) begin
                ctrl_q.run    <= bus_wdata[0];
                ctrl_q.clksel <= bus_wdata[2];
                ctrl_q.guard  <= bus_wdata[3];
                ctrl_q.presel <= bus_wdata[6:4];
            end
            if (expire_w && !ctrl_q.guard)      ctrl_q.tof <= 1'b1;
            else if (ctrl_wr && !bus_wdata[1])  ctrl_q.tof <= 1'b0;
            if (pass_we && bus_addr == ADDR_LOAD) load_q <= bus_wdata[CNT_W-1:0];
            if (feed_ok) shadow_q <= load_q;
        end
    end

    assign tmo_irq = ctrl_q.tof;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             armed,
    input logic             expire,
    input logic             guard,
    input logic             run_en,
    input logic             loading,
    input logic             counting,
    input logic [CNT_W-1:0] shadow,
    input logic [CNT_W-1:0] cnt_o,
    input logic             tmo_irq,
    input logic             rst_req
);
    a_r6_break_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_we && !(bus_addr == 2'd3 && bus_wdata == 8'h5A)) |=> rst_req);

    a_r7_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && guard) |=> rst_req);

    a_r8_timer_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !guard) |=> tmo_irq);

    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cnt_o));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        counting |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));

    a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> (cnt_o == $past(shadow)));
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .armed(armed_w), .expire(expire_w), .guard(ctrl_q.guard), .run_en(run_en),
    .loading(loading_w), .counting(counting_w), .shadow(shadow_q), .cnt_o(cnt_o),
    .tmo_irq(tmo_irq), .rst_req(rst_req)
);

// File: tb/test_wdg_guard.sv
`timescale 1ns/1ps
module test_wdg_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] cnt_o;
    logic       tmo_irq, rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    wdg_guard i_wdg_guard (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_o(cnt_o),
        .tmo_irq(tmo_irq), .rst_req(rst_req)
    );

    // behavioural reference model
    bit m_run, m_tof, m_clk, m_guard, m_armed, m_pend, m_rst;
    int m_psel, m_load, m_shadow, m_L, m_el, m_cnt, m_div;
    bit m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_tof = 0; m_clk = 0; m_guard = 0; m_armed = 0; m_pend = 1;
            m_rst = 0; m_psel = 0; m_load = 255; m_shadow = 255; m_L = 255;
            m_el = 0; m_cnt = 255; m_div = 0; m_live = 1;
        end else begin
            int  period;
            bit  tick, adv, feed, err, pass, expire, arm_n;
            period = 1 << (5 + m_psel);
            tick   = m_clk ? (slow_tick && m_div == 31) : 1'b1;
            adv    = tick && (m_run || m_guard);
            feed = 0; err = 0; pass = 0; expire = 0; arm_n = m_armed;
            if (bus_we) begin
                if (m_armed) begin
                    arm_n = 0;
                    if (bus_addr == 3 && bus_wdata == 8'h5A) feed = 1; else err = 1;
                end else if (bus_addr == 2 && bus_wdata == 8'hA5) arm_n = 1;
                else if (bus_addr < 2) pass = 1;
            end
            if (m_pend) begin
                if (adv && !feed) begin
                    m_pend = 0; m_L = m_shadow; m_el = 0; m_cnt = m_shadow;
                end
            end else if (feed) m_pend = 1;
            else if (adv) begin
                m_el++;
                if (m_el == (m_L + 1) * period) begin expire = 1; m_pend = 1; end
                else m_cnt = m_L - m_el / period;
            end
            m_rst = err || (expire && m_guard);
            if (expire && !m_guard) m_tof = 1;
            else if (pass && bus_addr == 0 && !bus_wdata[1]) m_tof = 0;
            if (pass && bus_addr == 0) begin
                m_run = bus_wdata[0]; m_clk = bus_wdata[2]; m_guard = bus_wdata[3];
                m_psel = int'(bus_wdata[6:4]);
            end
            if (pass && bus_addr == 1) m_load = bus_wdata;
            if (feed) m_shadow = m_load;
            if (slow_tick) m_div = (m_div + 1) % 32;
            m_armed = arm_n;
        end
    end

    // cycle-by-cycle comparison (away from the active edge)
    always @(negedge clk) begin
        cycles++;
        if (rst_n && m_live) begin
            checks++;
            if (cnt_o !== 8'(m_cnt)) begin errors++;
                $display("FAIL R3 cnt_o act=%0d exp=%0d t=%0t", cnt_o, m_cnt, $time); end
            checks++;
            if (tmo_irq !== m_tof) begin errors++;
                $display("FAIL R8 tmo_irq act=%0b exp=%0b t=%0t", tmo_irq, m_tof, $time); end
            checks++;
            if (rst_req !== m_rst) begin errors++;
                $display("FAIL R7 rst_req act=%0b exp=%0b t=%0t", rst_req, m_rst, $time); end
        end
    end

    // slow oscillator enable: one pulse every third cycle
    int sdiv = 0;
    always @(negedge clk) begin
        sdiv = (sdiv + 1) % 3;
        slow_tick <= (sdiv == 0);
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic feed();
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h5A);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (!rst_req && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt_o, 255);
        chk("R1 flag", tmo_irq, 0);
        chk("R1 rst", rst_req, 0);
        // R2 halted in timer mode
        repeat (40) @(negedge clk);
        chk("R2 halted count", cnt_o, 255);
        // R5 load + feed while halted: count still held
        wr(2'd1, 8'd3);
        chk("R5 load alone", cnt_o, 255);
        feed();
        repeat (5) @(negedge clk);
        chk("R2 halted after feed", cnt_o, 255);
        // start running in timer mode, P=0
        wr(2'd0, 8'h01);
        @(negedge clk);
        chk("R5 reload from shadow", cnt_o, 3);
        repeat (40) @(negedge clk);
        chk("R3 one step after 32 ticks", cnt_o, 2);
        seen = 0;
        n = 0;
        while (!tmo_irq && n < 500) begin @(negedge clk); n++; if (rst_req) seen = 1; end
        chk("R8 flag set on expiry", tmo_irq, 1);
        chk("R8 no reset in timer mode", seen, 0);
        // R8 flag write of 1 keeps, write of 0 clears
        wr(2'd0, 8'h03);
        chk("R8 write one keeps flag", tmo_irq, 1);
        wr(2'd0, 8'h01);
        chk("R8 clear flag", tmo_irq, 0);
        wr(2'd0, 8'h03);
        chk("R8 write one does not set", tmo_irq, 0);
        // R10 stray key writes
        wr(2'd3, 8'h5A);
        chk("R10 lone key two", rst_req, 0);
        wr(2'd2, 8'h11);
        chk("R10 wrong key one", rst_req, 0);
        // R6 sequence breaks
        wr(2'd2, 8'hA5);
        wr(2'd1, 8'h10);
        chk("R6 load write breaks", rst_req, 1);
        @(negedge clk);
        chk("R6 pulse one cycle", rst_req, 0);
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h00);
        chk("R6 wrong second key", rst_req, 1);
        wr(2'd2, 8'hA5);
        wr(2'd2, 8'hA5);
        chk("R6 repeated first key", rst_req, 1);
        // R3 with P=1: halt, program, feed, run
        wr(2'd0, 8'h10);
        wr(2'd1, 8'd2);
        feed();
        wr(2'd0, 8'h11);
        repeat (70) @(negedge clk);
        chk("R3 P=1 step", cnt_o, 1);
        // R7 guard mode, run bit clear, L=1 P=0
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd1);
        feed();
        wr(2'd0, 8'h08);
        wait_pulse(n);
        chk("R7 first guard reset", rst_req, 1);
        @(negedge clk);
        wait_pulse(n);
        chk("R4 guard period", n + 1, 2 * 32 + 1);
        // regular feeding keeps the reset away
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            feed();
            repeat (30) begin @(negedge clk); if (rst_req) seen = 1; end
        end
        chk("R7 feeding prevents reset", seen, 0);
        // R9 slow clock, timer mode, L=0 P=0
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd0);
        feed();
        wr(2'd0, 8'h05);
        repeat (1000) @(negedge clk);
        chk("R9 slow clock not yet expired", tmo_irq, 0);
        n = 0;
        while (!tmo_irq && n < 8000) begin @(negedge clk); n++; end
        chk("R9 slow clock expiry", tmo_irq, 1);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule